// File: doc/BRIEF.md
# Routed Interrupt Controller

This block collects a vector of external interrupt lines and steers each of them to one parent interrupt output of one processor core. Each source owns a routing byte: the upper nibble selects the parent output and the lower nibble selects the core. Every line passes through a two-stage synchronizer before it is examined. It is configured as level or edge sensitive, with a polarity bit that picks active-high or rising versus active-low or falling. A source only drives an output while its enable bit is set.

Software reaches the block over a small register bus. A request is presented on `bus_req` for one cycle and is always accepted, so the bus has no back-pressure and no ready signal. Writes carry byte enables. A read answers in the next cycle with `bus_rvalid` high for one cycle. Enable bits are never written directly. They change only through a write-one-to-set word and a write-one-to-clear word, so that concurrent drivers cannot undo each other's bits with read-modify-write. The same clear word also discards a latched edge.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, the enable, polarity and trigger-mode words and every routing byte read back as zero, and every bit of `irq_out` is low.
- R2: The routing byte of source s sits at byte address s, in word s/4 and byte lane s%4, in the range 0x00 to 0x1F. Bits 7:4 select the parent output (bit 4+p selects parent p) and bits 3:0 select the core (bit c selects core c). Each routing byte reads back what was last written to it.
- R3: A word read at 0x24 returns the current enable mask, with bit s for source s.
- R4: A write to 0x28 sets the enable of every source whose data bit is 1. Data bits that are 0 leave their enables unchanged.
- R5: A write to 0x2C clears the enable of every source whose data bit is 1. Data bits that are 0 leave their enables unchanged.
- R6: The word at 0x30 holds polarity, where 1 means active-high or rising and 0 means active-low or falling. The word at 0x34 holds the trigger mode, where 1 means edge and 0 means level. Both read back what was written.
- R7: A level-mode source reads as pending at 0x40, in bit s, exactly while its synchronized input equals its polarity bit.
- R8: An edge-mode source latches pending on the edge selected by its polarity and keeps it after the input returns to idle. The opposite edge does not latch.
- R9: A latched edge is cleared by writing a 1 to that source's bit at 0x2C, or by setting that source to level mode. Writing 0 bits at 0x2C leaves other latches intact.
- R10: Output bit `irq_out[c*NPAR+p]` is high when at least one source is enabled and pending and has routing bit 4+p and routing bit c set. A source that is pending but disabled drives nothing.
- R11: Read data and `bus_rvalid` appear one cycle after the request. Write-only and unmapped offsets read as zero. A byte whose byte enable is low is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NSRC | Asynchronous interrupt source lines |
| bus_req | input | 1 | Bus access presented this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address, word-aligned for word registers |
| bus_be | input | 4 | Byte enables for the write data lanes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq_out | output | NCORE*NPAR | Parent interrupt lines, index core*NPAR+parent |

## Verification
The hardest state to reach from the ports is an edge latch that must survive while its input, its polarity and its neighbours' clear bits all change around it. Reaching it takes careful ordering. The stimulus first programs the falling-edge source's trigger mode and then its polarity, while its input is held idle, so that reprogramming alone cannot create an edge. It then drives the wrong edge followed by the right one. After that it clears a neighbouring latch through the clear word and checks that the latch under test is still visible at 0x40. Only then does it switch the source to level mode, with the input parked at the inactive level, so that a read of zero proves the latch itself was dropped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  // word register offsets (byte addresses)
  localparam logic [7:0] OFS_EN_STAT = 8'h24;
  localparam logic [7:0] OFS_EN_SET  = 8'h28;
  localparam logic [7:0] OFS_EN_CLR  = 8'h2C;
  localparam logic [7:0] OFS_POL     = 8'h30;
  localparam logic [7:0] OFS_MODE    = 8'h34;
  localparam logic [7:0] OFS_PEND    = 8'h40;

  typedef struct packed {
    logic [3:0] par;   // one-hot parent output select
    logic [3:0] core;  // one-hot core select
  } route_t;
endpackage

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSRC-1:0] pol_i,
  input  logic [NSRC-1:0] mode_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] sync1_q, sync2_q, prev_q, latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= irq_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic active_lvl, edge_hit, lat_q;
    assign active_lvl = ~(sync2_q[s] ^ pol_i[s]);
    assign edge_hit   = (sync2_q[s] ^ prev_q[s]) & active_lvl;

    always_ff @(posedge clk) begin
      if (!rst_n) lat_q <= 1'b0;
      else        lat_q <= mode_i[s] & ~clr_i[s] & (lat_q | edge_hit);
    end

    assign latch_q[s] = lat_q;
    assign pend_o[s]  = mode_i[s] ? lat_q : active_lvl;
  end

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(latch_q & mode_i & ~clr_i) & ~latch_q) == '0));

  // R9
  latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_i | ~mode_i) & latch_q) == '0));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic [NSRC-1:0]   pend_i,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   pol_o,
  output logic [NSRC-1:0]   mode_o,
  output logic [NSRC-1:0]   clr_o,
  output route_t            route_o [NSRC]
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] W_EN_STAT = WA_W'(OFS_EN_STAT >> 2);
  localparam logic [WA_W-1:0] W_EN_SET  = WA_W'(OFS_EN_SET  >> 2);
  localparam logic [WA_W-1:0] W_EN_CLR  = WA_W'(OFS_EN_CLR  >> 2);
  localparam logic [WA_W-1:0] W_POL     = WA_W'(OFS_POL     >> 2);
  localparam logic [WA_W-1:0] W_MODE    = WA_W'(OFS_MODE    >> 2);
  localparam logic [WA_W-1:0] W_PEND    = WA_W'(OFS_PEND    >> 2);

  logic [WA_W-1:0]   wa;
  logic              wr, rd;
  logic [DATA_W-1:0] bmask;
  logic [NSRC-1:0]   wbits;
  logic [NSRC-1:0]   en_q, pol_q, mode_q;
  logic [DATA_W-1:0] rmux;

  assign wa = addr[ADDR_W-1:2];
  assign wr = req & we;
  assign rd = req & ~we;

  for (genvar l = 0; l < LANES; l++) begin : g_bm
    assign bmask[8*l +: 8] = {8{be[l]}};
  end

  assign wbits = NSRC'(wdata & bmask);
  assign clr_o = (wr && wa == W_EN_CLR) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
    end else if (wr) begin
      case (wa)
        W_EN_SET: en_q   <= en_q | wbits;
        W_EN_CLR: en_q   <= en_q & ~wbits;
        W_POL:    pol_q  <= (pol_q & ~NSRC'(bmask)) | wbits;
        W_MODE:   mode_q <= (mode_q & ~NSRC'(bmask)) | wbits;
        default:  ;
      endcase
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_route
    localparam logic [WA_W-1:0] RW = WA_W'(s / LANES);
    localparam int LN = s % LANES;
    route_t rt_q;
    always_ff @(posedge clk) begin
      if (!rst_n) rt_q <= '0;
      else if (wr && wa == RW && be[LN]) rt_q <= wdata[8*LN +: 8];
    end
    assign route_o[s] = rt_q;
  end

  always_comb begin
    rmux = '0;
    case (wa)
      W_EN_STAT: rmux[NSRC-1:0] = en_q;
      W_POL:     rmux[NSRC-1:0] = pol_q;
      W_MODE:    rmux[NSRC-1:0] = mode_q;
      W_PEND:    rmux[NSRC-1:0] = pend_i;
      default: begin
        for (int s = 0; s < NSRC; s++)
          if (wa == WA_W'(s / LANES)) rmux[8*(s%LANES) +: 8] = route_o[s];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rmux;
    end
  end

  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign mode_o = mode_q;

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wa == W_EN_SET) |=> (en_q == ($past(en_q) | $past(wbits))));

  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wa == W_EN_CLR) |=> (en_q == ($past(en_q) & ~$past(wbits))));

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);

  // R11
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid);
endmodule

// File: rtl/irqc_route.sv
module irqc_route
  import irqc_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NPAR  = 4,
  parameter int NCORE = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       active_i,
  input  route_t                route_i [NSRC],
  output logic [NCORE*NPAR-1:0] irq_o
);
  localparam int NOUT = NCORE * NPAR;
  logic [NOUT-1:0] hit;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar p = 0; p < NPAR; p++) begin : g_par
      always_comb begin
        hit[c*NPAR+p] = 1'b0;
        for (int s = 0; s < NSRC; s++)
          hit[c*NPAR+p] = hit[c*NPAR+p] |
            (active_i[s] & route_i[s].par[p] & route_i[s].core[c]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= hit;
  end

  // R10
  out_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> $past(|active_i));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NPAR   = 4,
  parameter int NCORE  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       irq_in,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [3:0]            bus_be,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_rvalid,
  output logic [NCORE*NPAR-1:0] irq_out
);
  logic [NSRC-1:0] en, pol, mode, clr, pend;
  route_t          route [NSRC];

  irqc_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .addr(bus_addr),
    .be(bus_be), .wdata(bus_wdata), .rdata(bus_rdata), .rvalid(bus_rvalid),
    .pend_i(pend), .en_o(en), .pol_o(pol), .mode_o(mode), .clr_o(clr),
    .route_o(route)
  );

  irqc_detect #(.NSRC(NSRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pol_i(pol), .mode_i(mode),
    .clr_i(clr), .pend_o(pend)
  );

  irqc_route #(.NSRC(NSRC), .NPAR(NPAR), .NCORE(NCORE)) u_route (
    .clk(clk), .rst_n(rst_n), .active_i(en & pend), .route_i(route),
    .irq_o(irq_out)
  );

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_out == '0));
endmodule

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb_top;
  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;  // write data, or expected read data
    logic [7:0]  req;
  } op_t;

  localparam int NOPS = 20;
  localparam op_t OPS [NOPS] = '{
    '{1'b1, 8'h00, 4'hF, 32'h11223344, 8'd2},  // R2 routing word 0
    '{1'b0, 8'h00, 4'hF, 32'h11223344, 8'd2},
    '{1'b1, 8'h1C, 4'h4, 32'hAABBCCDD, 8'd11}, // R11 one lane only
    '{1'b0, 8'h1C, 4'hF, 32'h00BB0000, 8'd11},
    '{1'b1, 8'h28, 4'hF, 32'h000000F0, 8'd4},  // R4
    '{1'b0, 8'h24, 4'hF, 32'h000000F0, 8'd3},  // R3
    '{1'b1, 8'h28, 4'hF, 32'h00000003, 8'd4},
    '{1'b0, 8'h24, 4'hF, 32'h000000F3, 8'd4},
    '{1'b1, 8'h2C, 4'hF, 32'h00000030, 8'd5},  // R5
    '{1'b0, 8'h24, 4'hF, 32'h000000C3, 8'd5},
    '{1'b1, 8'h30, 4'hF, 32'hDEADBEEF, 8'd6},  // R6 polarity
    '{1'b0, 8'h30, 4'hF, 32'hDEADBEEF, 8'd6},
    '{1'b1, 8'h34, 4'h1, 32'h12345678, 8'd6},  // R6 mode, lane 0
    '{1'b0, 8'h34, 4'hF, 32'h00000078, 8'd6},
    '{1'b0, 8'h28, 4'hF, 32'h00000000, 8'd11}, // R11 write-only
    '{1'b0, 8'h50, 4'hF, 32'h00000000, 8'd11}, // R11 unmapped
    '{1'b1, 8'h2C, 4'hF, 32'hFFFFFFFF, 8'd5},
    '{1'b0, 8'h24, 4'hF, 32'h00000000, 8'd5},
    '{1'b1, 8'h34, 4'hF, 32'h00000000, 8'd6},
    '{1'b0, 8'h34, 4'hF, 32'h00000000, 8'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] irq_out;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_route_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = b; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = 4'hF;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
    v = bus_rvalid;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic v;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    check("R1 irq_out", 32'(irq_out), 32'h0);
    bus_read(8'h24, d, v); check("R1 enable", d, 32'h0);
    bus_read(8'h30, d, v); check("R1 polarity", d, 32'h0);
    bus_read(8'h34, d, v); check("R1 mode", d, 32'h0);
    bus_read(8'h0C, d, v); check("R1 routing", d, 32'h0);
    check("R11 rvalid", 32'(v), 32'h1);
    wait_cyc(1);
    check("R11 rvalid drops", 32'(bus_rvalid), 32'h0);

    // register table
    for (int i = 0; i < NOPS; i++) begin
      if (OPS[i].we) bus_write(OPS[i].addr, OPS[i].be, OPS[i].data);
      else begin
        bus_read(OPS[i].addr, d, v);
        check($sformatf("R%0d table row %0d", OPS[i].req, i), d, OPS[i].data);
      end
    end

    // R7 level detection, active high and active low
    bus_write(8'h30, 4'hF, 32'hFFFFFFFF);
    wait_cyc(4);
    bus_read(8'h40, d, v); check("R7 idle pending", d, 32'h0);
    irq_in[5] = 1'b1;
    wait_cyc(4);
    bus_read(8'h40, d, v); check("R7 high level", d, 32'h00000020);
    bus_write(8'h30, 4'hF, 32'hFFFFFFBF);
    wait_cyc(2);
    bus_read(8'h40, d, v); check("R7 low level", d, 32'h00000060);
    bus_write(8'h30, 4'hF, 32'hFFFFFFFF);

    // R10 routing: source 5 to parent 2, core 1 -> irq_out bit 6
    bus_write(8'h04, 4'hF, 32'h00004200);
    wait_cyc(3);
    check("R10 disabled source silent", 32'(irq_out), 32'h0);
    bus_write(8'h28, 4'hF, 32'h00000020);
    wait_cyc(2);
    check("R10 routed output", 32'(irq_out), 32'h00000040);
    bus_write(8'h2C, 4'hF, 32'h00000020);
    wait_cyc(2);
    check("R10 output after disable", 32'(irq_out), 32'h0);
    irq_in[5] = 1'b0;

    // R8 rising edge on source 9 -> parent 0, core 3 -> irq_out bit 12
    bus_write(8'h08, 4'hF, 32'h00001800);
    bus_write(8'h34, 4'hF, 32'h00000600);
    bus_write(8'h30, 4'hF, 32'hFFFFFBFF);
    bus_write(8'h28, 4'hF, 32'h00000200);
    wait_cyc(4);
    bus_read(8'h40, d, v); check("R8 no edge yet", d, 32'h0);
    irq_in[9] = 1'b1;
    wait_cyc(3);
    irq_in[9] = 1'b0;
    wait_cyc(6);
    bus_read(8'h40, d, v); check("R8 rising latched", d, 32'h00000200);
    check("R10 edge source output", 32'(irq_out), 32'h00001000);

    // R8 falling edge on source 10: rise must not latch, fall must
    irq_in[10] = 1'b1;
    wait_cyc(5);
    bus_read(8'h40, d, v); check("R8 wrong edge ignored", d, 32'h00000200);
    irq_in[10] = 1'b0;
    wait_cyc(5);
    bus_read(8'h40, d, v); check("R8 falling latched", d, 32'h00000600);

    // R9 clear by write-one-to-clear, neighbour kept
    bus_write(8'h2C, 4'hF, 32'h00000200);
    wait_cyc(2);
    bus_read(8'h40, d, v); check("R9 clear one latch", d, 32'h00000400);
    check("R9 output after clear", 32'(irq_out), 32'h0);
    irq_in[10] = 1'b1;
    wait_cyc(5);
    bus_read(8'h40, d, v); check("R9 latch survives", d, 32'h00000400);
    // R9 clear by switching to level mode (input inactive)
    bus_write(8'h34, 4'hF, 32'h00000200);
    wait_cyc(2);
    bus_read(8'h40, d, v); check("R9 level switch drops latch", d, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule